// File: doc/BRIEF.md
# Serial Port Bit-Clock Generator

This block produces the bit clock that a buffered serial port uses to shift transmit and receive data. It divides one of two sources by a programmable 8-bit value. The first source is the system clock the block itself runs on. The second is an external clock pin, which is brought into the system clock domain before use. The whole block runs on the system clock. Every rising edge of the selected source, after synchronisation, counts as one source tick, and the divider advances only on those ticks.

The output clock lasts D+1 ticks for a nonzero divide value D. When D is odd, the clock is high for half of that and low for the other half. When D is even, the high phase is one tick longer than the low phase. A value of zero gives one tick high and one tick low. A polarity input can invert the waveform. Two single-cycle strobes mark the rising and falling edges of the output, so that shift logic in the same clock domain can act on them.

A new divide value is picked up only when a new period begins, so a write never produces a runt pulse. An enable input stops the block and clears it. On restart, the first tick after enable opens a fresh period.

Top module: `sp_bclk_gen`

## Requirements
- R1: With `src_int`=1 every system clock cycle is a source tick and `ext_clk` has no effect; with `src_int`=0 each rising edge of `ext_clk`, after a two-flop synchroniser, is one tick and cycles without an edge are not ticks.
- R2: For an even nonzero divide value D (invert off), the output is high for D/2+1 ticks and then low for D/2 ticks.
- R3: For an odd divide value D (invert off), the output is high for (D+1)/2 ticks and then low for (D+1)/2 ticks.
- R4: A divide value of 0 makes the output high for one tick and low for one tick.
- R5: With `invert`=1 the running output is the complement of the generated wave, so it is low for the high length and high for the low length; while the block is idle it is still 0.
- R6: `rise_stb` is 1 for exactly the first cycle in which `bclk` is 1 after being 0, and `fall_stb` is 1 for exactly the first cycle in which `bclk` is 0 after being 1; the two strobes are never 1 together.
- R7: `div` is sampled only at the tick that starts a high phase of the generated wave; a change made during a period leaves the rest of that period unchanged and applies from the next period on.
- R8: While reset is active or `en` is 0, `bclk` is 0 one cycle after `en` is seen low and the counter is cleared; the first tick after `en` is seen high starts a high phase, so in internal mode with invert off `bclk` is 1 in the cycle after the first edge that samples `en` high.
- R9: The output never has a period shorter than two system clock cycles; `rise_stb` is never 1 in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; every register in the block runs on it |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside the block |
| en | input | 1 | Run enable; 0 holds the output low and clears the divider |
| src_int | input | 1 | Source select: 1 = system clock, 0 = external clock pin |
| ext_clk | input | 1 | External source clock; must be slower than half the system clock |
| div | input | 8 | Divide value D |
| invert | input | 1 | Output polarity; 1 inverts the running output |
| bclk | output | 1 | Generated bit clock |
| rise_stb | output | 1 | One-cycle strobe on each rising edge of `bclk` |
| fall_stb | output | 1 | One-cycle strobe on each falling edge of `bclk` |

## Verification
The hardest case to reach from the ports is a divide change in the middle of a period. The stimulus has to land after a high phase has already started and before that period ends, and the only thing the ports reveal is that the old low length is still in force. The bench waits for a rising strobe and writes the new value in that same cycle. It then measures the remainder of the current period and the whole of the next one. In external mode, the tick spacing is pinned down by toggling the pin every three system cycles, so each source period is an exact six-cycle multiple that the bench can count.

// File: rtl/sp_bclk_pkg.sv
package sp_bclk_pkg;

  typedef enum logic {
    SRC_EXT = 1'b0,
    SRC_INT = 1'b1
  } src_sel_e;

  typedef enum logic {
    PH_LOW  = 1'b0,
    PH_HIGH = 1'b1
  } phase_e;

endpackage

// File: rtl/sp_bclk_tick_src.sv
module sp_bclk_tick_src
  import sp_bclk_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic src_int,
  input  logic ext_clk,
  output logic tick
);

  localparam int CHAIN = SYNC_STAGES + 1;

  logic [CHAIN-1:0] sync_q;
  logic [CHAIN-1:0] sync_d;
  logic             ext_edge;
  src_sel_e         sel;

  // chain: stages 0..SYNC_STAGES-1 synchronise, last stage holds history
  for (genvar i = 0; i < CHAIN; i++) begin : g_chain
    if (i == 0) begin : g_head
      assign sync_d[i] = ext_clk;
    end else begin : g_link
      assign sync_d[i] = sync_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  always_comb begin
    sel      = src_sel_e'(src_int);
    ext_edge = sync_q[CHAIN-2] & ~sync_q[CHAIN-1];
    tick     = (sel == SRC_INT) ? 1'b1 : ext_edge;
  end

endmodule

// File: rtl/sp_bclk_divider.sv
module sp_bclk_divider
  import sp_bclk_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick,
  input  logic [DIV_W-1:0] div,
  output logic             running,
  output phase_e           phase
);

  localparam logic [DIV_W-1:0] ONE = {{(DIV_W-1){1'b0}}, 1'b1};

  logic             run_q,  run_n;
  phase_e           ph_q,   ph_n;
  logic [DIV_W-1:0] cnt_q,  cnt_n;
  logic [DIV_W-1:0] dact_q, dact_n;
  logic             cnt_end;
  logic             start_hi;

  // low phase length minus one: even nonzero values run one tick short
  function automatic logic [DIV_W-1:0] low_m1(input logic [DIV_W-1:0] d);
    if (!d[0] && (d != '0)) return (d >> 1) - ONE;
    else                    return d >> 1;
  endfunction

  always_comb begin
    run_n    = run_q;
    ph_n     = ph_q;
    cnt_n    = cnt_q;
    dact_n   = dact_q;
    cnt_end  = (cnt_q == '0);
    start_hi = !run_q || ((ph_q == PH_LOW) && cnt_end);
    if (!en) begin
      run_n = 1'b0;
      ph_n  = PH_LOW;
      cnt_n = '0;
    end else if (tick) begin
      if (start_hi) begin
        run_n  = 1'b1;
        ph_n   = PH_HIGH;
        dact_n = div;
        cnt_n  = div >> 1;   // high length minus one, all values
      end else if (cnt_end) begin
        ph_n  = PH_LOW;
        cnt_n = low_m1(dact_q);
      end else begin
        cnt_n = cnt_q - ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      ph_q   <= PH_LOW;
      cnt_q  <= '0;
      dact_q <= '0;
    end else begin
      run_q  <= run_n;
      ph_q   <= ph_n;
      cnt_q  <= cnt_n;
      dact_q <= dact_n;
    end
  end

  assign running = run_q;
  assign phase   = ph_q;

endmodule

// File: rtl/sp_bclk_shaper.sv
module sp_bclk_shaper
  import sp_bclk_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   running,
  input  phase_e phase,
  input  logic   invert,
  output logic   bclk,
  output logic   rise_stb,
  output logic   fall_stb
);

  logic out_c;
  logic prev_q, prev_n;

  always_comb begin
    out_c    = running & ((phase == PH_HIGH) ^ invert);
    prev_n   = out_c;
    bclk     = out_c;
    rise_stb = out_c & ~prev_q;
    fall_stb = ~out_c & prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= prev_n;
  end

endmodule

// File: rtl/sp_bclk_gen.sv
module sp_bclk_gen
  import sp_bclk_pkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             src_int,
  input  logic             ext_clk,
  input  logic [DIV_W-1:0] div,
  input  logic             invert,
  output logic             bclk,
  output logic             rise_stb,
  output logic             fall_stb
);

  logic [RST_STAGES-1:0] rst_pipe_q;
  logic                  core_rst_n;
  logic                  tick;
  logic                  running;
  phase_e                phase;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[RST_STAGES-2:0], 1'b1};
  end
  assign core_rst_n = rst_pipe_q[RST_STAGES-1];

  sp_bclk_tick_src #(.SYNC_STAGES(SYNC_STAGES)) u_src (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .src_int (src_int),
    .ext_clk (ext_clk),
    .tick    (tick)
  );

  sp_bclk_divider #(.DIV_W(DIV_W)) u_div (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .en      (en),
    .tick    (tick),
    .div     (div),
    .running (running),
    .phase   (phase)
  );

  sp_bclk_shaper u_shp (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .running  (running),
    .phase    (phase),
    .invert   (invert),
    .bclk     (bclk),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb)
  );

endmodule

// File: rtl/sp_bclk_gen_chk.sv
module sp_bclk_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic src_int,
  input logic invert,
  input logic bclk,
  input logic rise_stb,
  input logic fall_stb
);

  assert_rise_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rise_stb |-> bclk);

  assert_fall_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fall_stb |-> !bclk);

  assert_strobes_apart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_stb && fall_stb));

  assert_idle_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !bclk);

  assert_start_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(en) && src_int && !invert && $past(rst_n)) |=> bclk);

  assert_min_period_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rise_stb |=> !rise_stb);

endmodule

bind sp_bclk_gen sp_bclk_gen_chk u_chk (
  .clk      (clk),
  .rst_n    (core_rst_n),
  .en       (en),
  .src_int  (src_int),
  .invert   (invert),
  .bclk     (bclk),
  .rise_stb (rise_stb),
  .fall_stb (fall_stb)
);

// File: tb/sp_bclk_gen_test.sv
`timescale 1ns/1ps
module sp_bclk_gen_test;

  typedef struct packed {
    logic        src;
    logic        inv;
    logic [7:0]  dv;
    logic [10:0] hi;
    logic [10:0] lo;
  } vec_t;

  // expected high/low in system cycles; external source ticks every 6 cycles
  localparam int NVEC = 12;
  localparam vec_t VEC [NVEC] = '{
    '{1'b1, 1'b0, 8'd2,   11'd2,   11'd1},
    '{1'b1, 1'b0, 8'd3,   11'd2,   11'd2},
    '{1'b1, 1'b0, 8'd0,   11'd1,   11'd1},
    '{1'b1, 1'b0, 8'd1,   11'd1,   11'd1},
    '{1'b1, 1'b0, 8'd8,   11'd5,   11'd4},
    '{1'b1, 1'b0, 8'd255, 11'd128, 11'd128},
    '{1'b1, 1'b0, 8'd254, 11'd128, 11'd127},
    '{1'b1, 1'b1, 8'd6,   11'd3,   11'd4},
    '{1'b0, 1'b0, 8'd4,   11'd18,  11'd12},
    '{1'b0, 1'b0, 8'd1,   11'd6,   11'd6},
    '{1'b0, 1'b1, 8'd2,   11'd6,   11'd12},
    '{1'b1, 1'b1, 8'd0,   11'd1,   11'd1}
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       en;
  logic       src_int;
  logic       ext_clk;
  logic [7:0] div;
  logic       invert;
  logic       bclk, rise_stb, fall_stb;
  int         checks = 0;
  int         failures = 0;
  int         cyc = 0;

  always #2 clk = ~clk;

  sp_bclk_gen uut (
    .clk(clk), .rst_n(rst_n), .en(en), .src_int(src_int), .ext_clk(ext_clk),
    .div(div), .invert(invert), .bclk(bclk), .rise_stb(rise_stb),
    .fall_stb(fall_stb)
  );

  initial begin
    ext_clk = 1'b0;
    forever begin
      repeat (3) @(negedge clk);
      ext_clk = ~ext_clk;
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cyc, 150000);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic measure(output int hi, output int lo, output bit fs, output bit rs);
    do @(negedge clk); while (!rise_stb);
    hi = 0;
    while (bclk) begin hi++; @(negedge clk); end
    fs = fall_stb;
    lo = 0;
    while (!bclk) begin lo++; @(negedge clk); end
    rs = rise_stb;
  endtask

  initial begin
    int  hi, lo, hi2, lo2, seen;
    bit  fs, rs;
    string tag;
    rst_n = 1'b0; en = 1'b0; src_int = 1'b1; div = 8'd3; invert = 1'b0;
    repeat (3) @(negedge clk);
    // R8: reset state
    check(!bclk && !rise_stb && !fall_stb, "R8 reset", bclk, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      en = 1'b0;
      @(negedge clk);
      src_int = VEC[i].src; invert = VEC[i].inv; div = VEC[i].dv;
      en = 1'b1;
      tag = (VEC[i].dv == 0) ? "R4/R9" : (VEC[i].dv[0] ? "R3" : "R2");
      if (VEC[i].inv) tag = {tag, "/R5"};
      if (!VEC[i].src) tag = {tag, "/R1"};
      measure(hi, lo, fs, rs);
      check(hi == int'(VEC[i].hi), {tag, " high"}, hi, int'(VEC[i].hi));
      check(lo == int'(VEC[i].lo), {tag, " low"}, lo, int'(VEC[i].lo));
      check(fs, "R6 fall strobe", fs, 1);
      check(rs, "R6 rise strobe", rs, 1);
    end

    // R8: start after enable, internal source, invert off
    en = 1'b0; @(negedge clk);
    src_int = 1'b1; invert = 1'b0; div = 8'd3;
    @(negedge clk);
    en = 1'b1;
    @(negedge clk);
    check(bclk && rise_stb, "R8 first edge rising", bclk, 1);

    // R8: disable during high, then held low while ext_clk toggles
    src_int = 1'b0;
    do @(negedge clk); while (!bclk);
    en = 1'b0;
    @(negedge clk);
    check(!bclk && fall_stb, "R8 disable low", bclk, 0);
    seen = 0;
    repeat (30) begin @(negedge clk); if (bclk) seen++; end
    check(seen == 0, "R8 idle stays low", seen, 0);

    // R7: divide change mid-period applies from next period
    src_int = 1'b1; div = 8'd9; invert = 1'b0;
    @(negedge clk);
    en = 1'b1;
    do @(negedge clk); while (!rise_stb);
    div = 8'd1;
    hi = 0; while (bclk)  begin hi++; @(negedge clk); end
    lo = 0; while (!bclk) begin lo++; @(negedge clk); end
    hi2 = 0; while (bclk)  begin hi2++; @(negedge clk); end
    lo2 = 0; while (!bclk) begin lo2++; @(negedge clk); end
    check(hi == 5, "R7 old high kept", hi, 5);
    check(lo == 5, "R7 old low kept", lo, 5);
    check(hi2 == 1, "R7 new high", hi2, 1);
    check(lo2 == 1, "R7 new low", lo2, 1);

    en = 1'b0;
    repeat (2) @(negedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule